// File: doc/BRIEF.md
# Read Output Pipeline with Selectable Deselect Latency

This block sits between the array of a synchronous memory and its shared data pins. It receives the commands as they are presented on each cycle (read, write, deselect, or none), the data the array returns during the cycle after a read is captured, and two static mode inputs. From these it produces the data output word and a drive-enable flag. The drive-enable flag stands for the tri-state control of the shared bus: a low flag means the pins float so that another agent can drive them.

One mode input sets the read latency. In flow-through operation the array data goes straight to the outputs. In pipelined operation the data passes through an output register first. The other mode input sets when a deselect takes effect. With dual-cycle deselect, a deselect travels through the same depth as a read. With single-cycle deselect, it acts one stage earlier, so the drivers release one cycle sooner. The output-enable input and the sleep input gate the drivers without waiting for a clock edge. While sleep is high, all registered state is frozen, so nothing is lost.

Top module: `rd_out_pipe`

## Requirements
- R1: With `mode_pipe`=1, a read presented in cycle c takes the `rd_data` word seen in cycle c+1 into a register. That word appears on `dq_out` with `dq_drive`=1 from cycle c+2, and no earlier.
- R2: With `mode_pipe`=0, a read presented in cycle c turns on `dq_drive` in cycle c+1, and `dq_out` follows `rd_data` combinationally in that cycle.
- R3: With `mode_dual`=1, a deselect presented in cycle c keeps the drivers on for the same depth as a read. They go off from cycle c+2 when pipelined and from cycle c+1 when flow-through.
- R4: With `mode_dual`=0, a deselect acts one stage earlier than a read. The drivers go off from cycle c+1 when pipelined, and already in cycle c when flow-through.
- R5: A cycle with no command leaves the driver state unchanged, so drivers that are on stay on.
- R6: `oe_n`=1 forces `dq_drive` low at once. Releasing it restores the drive state and data without any clock edge.
- R7: A write forces `dq_drive` low in the cycle it is presented and in the next cycle. It also clears the driver state, so a later read is needed to turn the drivers on again.
- R8: While `sleep`=1, `dq_drive` is low, commands are ignored and every register keeps its value. After `sleep` falls, the previous drive state and output word return.
- R9: When commands coincide, a write beats a deselect, and a deselect beats a read.
- R10: Reset clears all state. `dq_drive` is then low, and `dq_out` is all zeros whenever `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Low-power hold: freezes state and releases the drivers |
| mode_pipe | input | 1 | Static: 1 = pipelined, 0 = flow-through |
| mode_dual | input | 1 | Static: 1 = dual-cycle deselect, 0 = single-cycle deselect |
| oe_n | input | 1 | Asynchronous output enable, active low |
| cmd_rd | input | 1 | Read command presented this cycle |
| cmd_wr | input | 1 | Write command presented this cycle |
| cmd_desel | input | 1 | Deselect command presented this cycle |
| rd_data | input | DW | Array read word, valid the cycle after a read is captured |
| dq_out | output | DW | Output data word, zero while not driving |
| dq_drive | output | 1 | Drive enable for the shared data pins |

## Verification
If the delay stages hold a wrong value, the fault shows on `dq_drive` one or two cycles after the command, according to the modes. The drivers then release a cycle too early or too late, or come on before the read data is ready. A stale or missing capture in the output register shows up in the first pipelined cycle that drives. A write or sleep that fails to cut or freeze the stages shows up as drive after the write, or as a different word once sleep ends. Every mode pairing is run through read, deselect and idle sequences, so a latency that is off by one stage changes the drive flag within two cycles.

// File: rtl/rd_out_pipe.sv
module rd_out_pipe #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          mode_pipe,
  input  logic          mode_dual,
  input  logic          oe_n,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  input  logic          cmd_desel,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_drive
);

  logic          st_in, st1, st2;
  logic          s1_rd, s1_wr;
  logic [DW-1:0] dout_q;
  logic          rd_lvl, pre_lvl, base_on;

  // drive state after the commands seen so far; write beats deselect beats read
  assign st_in = (cmd_wr | cmd_desel) ? 1'b0 : (cmd_rd ? 1'b1 : st1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1    <= 1'b0;
      st2    <= 1'b0;
      s1_rd  <= 1'b0;
      s1_wr  <= 1'b0;
      dout_q <= '0;
    end else if (!sleep) begin
      st1   <= st_in;
      st2   <= st1;
      s1_rd <= cmd_rd & ~cmd_wr & ~cmd_desel;
      s1_wr <= cmd_wr;
      if (s1_rd) dout_q <= rd_data;
    end
  end

  // stage at read depth, and the stage one shallower
  assign rd_lvl  = mode_pipe ? st2 : st1;
  assign pre_lvl = mode_pipe ? st1 : st_in;
  assign base_on = rd_lvl & (mode_dual | pre_lvl);

  assign dq_drive = base_on & ~oe_n & ~sleep & ~cmd_wr & ~s1_wr;
  assign dq_out   = dq_drive ? (mode_pipe ? dout_q : rd_data) : '0;

  AST_DCD_PIPE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && mode_dual && cmd_desel && !cmd_wr && !sleep ##1 !sleep) |=> !dq_drive); // R3

  AST_SCD_PIPE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && !mode_dual && cmd_desel && !sleep) |=> !dq_drive); // R4

  AST_SCD_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && !mode_dual && cmd_desel) |-> !dq_drive); // R4

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drive) |-> !oe_n); // R6

  AST_WR_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !sleep) |=> !dq_drive); // R7

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(dout_q) && $stable(st1) && $stable(st2))); // R8

endmodule

// File: tb/rd_out_pipe_test.sv
module rd_out_pipe_test;
  localparam int DW = 36;
  localparam logic [1:0] C_ID = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_DS = 2'd3;
  localparam int NV = 25;
  // pipe, dual, cmd, data, oe_n, exp drive, exp dq
  localparam logic [21:0] VEC [0:NV-1] = '{
    {1'b1,1'b0,C_RD,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b0,C_RD,8'h11,1'b0,1'b0,8'h00},
    {1'b1,1'b0,C_RD,8'h22,1'b0,1'b1,8'h11},
    {1'b1,1'b0,C_DS,8'h33,1'b0,1'b1,8'h22},
    {1'b1,1'b0,C_ID,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b0,C_ID,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_RD,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_RD,8'h44,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_DS,8'h55,1'b0,1'b1,8'h44},
    {1'b1,1'b1,C_ID,8'h00,1'b0,1'b1,8'h55},
    {1'b1,1'b1,C_ID,8'h00,1'b0,1'b0,8'h00},
    {1'b0,1'b0,C_RD,8'h00,1'b0,1'b0,8'h00},
    {1'b0,1'b0,C_RD,8'h66,1'b0,1'b1,8'h66},
    {1'b0,1'b0,C_DS,8'h77,1'b0,1'b0,8'h00},
    {1'b0,1'b0,C_ID,8'h00,1'b0,1'b0,8'h00},
    {1'b0,1'b1,C_RD,8'h00,1'b0,1'b0,8'h00},
    {1'b0,1'b1,C_DS,8'h88,1'b0,1'b1,8'h88},
    {1'b0,1'b1,C_ID,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_RD,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_ID,8'h99,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_ID,8'h00,1'b1,1'b0,8'h00},
    {1'b1,1'b1,C_ID,8'h00,1'b0,1'b1,8'h99},
    {1'b1,1'b1,C_WR,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_ID,8'h00,1'b0,1'b0,8'h00},
    {1'b1,1'b1,C_ID,8'h00,1'b0,1'b0,8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, mode_pipe = 1'b1, mode_dual = 1'b0;
  logic oe_n = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_desel = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] dq_out;
  logic dq_drive;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rd_out_pipe #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .mode_pipe(mode_pipe), .mode_dual(mode_dual),
    .oe_n(oe_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_desel(cmd_desel),
    .rd_data(rd_data), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  function automatic string row_req(int i);
    if (i <= 2 || i == 6 || i == 7 || i == 18 || i == 19) return "R1";
    if (i == 11 || i == 12 || i == 15) return "R2";
    if (i == 8 || i == 9 || i == 10 || i == 16 || i == 17) return "R3";
    if (i <= 5 || i == 13 || i == 14) return "R4";
    if (i == 20 || i == 21) return "R6";
    return "R7";
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic cyc(logic [1:0] c, logic [7:0] d);
    @(negedge clk);
    cmd_rd = (c == C_RD); cmd_wr = (c == C_WR); cmd_desel = (c == C_DS);
    rd_data = DW'(d);
    #1;
  endtask

  task automatic expect_out(string req, logic drv, logic [7:0] dq);
    chk(req, "drive", DW'(dq_drive), DW'(drv));
    chk(req, "dq", dq_out, DW'(dq));
  endtask

  initial begin
    #1;
    chk("R10", "drive in reset", DW'(dq_drive), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_pipe = VEC[i][21]; mode_dual = VEC[i][20];
      cmd_rd = (VEC[i][19:18] == C_RD); cmd_wr = (VEC[i][19:18] == C_WR);
      cmd_desel = (VEC[i][19:18] == C_DS);
      rd_data = DW'(VEC[i][17:10]); oe_n = VEC[i][9];
      #1;
      chk(row_req(i), "drive", DW'(dq_drive), DW'(VEC[i][8]));
      chk(row_req(i), "dq", dq_out, DW'(VEC[i][7:0]));
    end
    mode_pipe = 1'b1; mode_dual = 1'b1;
    cyc(C_RD, 8'h00); expect_out("R1", 1'b0, 8'h00);
    cyc(C_ID, 8'hA1); expect_out("R1", 1'b0, 8'h00);
    cyc(C_ID, 8'h00); expect_out("R5", 1'b1, 8'hA1);
    @(negedge clk); sleep = 1'b1;
    cyc(C_DS, 8'h00); expect_out("R8", 1'b0, 8'h00);
    cyc(C_ID, 8'h00); expect_out("R8", 1'b0, 8'h00);
    @(negedge clk); sleep = 1'b0;
    cyc(C_ID, 8'h00); expect_out("R8", 1'b1, 8'hA1);
    @(negedge clk); mode_dual = 1'b0;
    @(negedge clk); cmd_rd = 1'b1; cmd_desel = 1'b1; cmd_wr = 1'b0; rd_data = '0; #1;
    expect_out("R9", 1'b1, 8'hA1);
    cyc(C_ID, 8'h00); expect_out("R9", 1'b0, 8'h00);
    @(negedge clk); cmd_rd = 1'b1; cmd_wr = 1'b1; cmd_desel = 1'b0; #1;
    expect_out("R7", 1'b0, 8'h00);
    cyc(C_ID, 8'h00); expect_out("R7", 1'b0, 8'h00);
    cyc(C_ID, 8'h00); expect_out("R9", 1'b0, 8'h00);
    cyc(C_RD, 8'h00); expect_out("R1", 1'b0, 8'h00);
    cyc(C_ID, 8'hB2); expect_out("R1", 1'b0, 8'h00);
    cyc(C_ID, 8'h00); expect_out("R5", 1'b1, 8'hB2);
    @(negedge clk); rst_n = 1'b0; #1;
    expect_out("R10", 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(C_ID, 8'h5A); expect_out("R10", 1'b0, 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog got=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule